// File: doc/BRIEF.md
# Character-Granular Horizontal Sync Generator

This block produces the horizontal sync timing for a dot-clocked flat-panel interface. One dot is processed per clock. A dot counter walks through the eight dots of each character, and a character counter walks across the line. From these two counters the block derives one sync pulse per line. The pulse is driven on two identical registered outputs: a line-clock strobe and an Hsync.

The pulse placement is programmed through a 16-bit configuration word on a plain write/read port. The word holds a pulse length and a pulse location, both counted in characters and both stored minus one. Two more inputs give the line length and the visible display width, also in characters. These inputs are expected to stay static while the block runs.

A programmed word is held in a shadow copy and moves into service only at a line boundary. The settings in service are checked against the line length and the display width. Any violation latches a sticky error flag, which silences both sync outputs until reset.

Top module: `hsync_timing_gen`

## Requirements
- R1: While reset is asserted and up to the first clock edge after it is released, the read port returns 0x0050 (length field 0, location field 0x50), and both sync outputs and the error flag are low.
- R2: A write stores bits 15:12 of the write data as the length field L and bits 7:0 as the location field P. The read port returns the most recently written L and P in those same bit positions, even before they are put in service.
- R3: Read bits 11:8 are always zero, whatever was written to them.
- R4: A line lasts (T+1)×8 clocks, where T is the line-length input. The dot counter steps 0 to 7 and wraps, and the character counter steps 0 to T and wraps.
- R5: The period from reset release to the first clock edge is dot 1 of the first line. Each clock edge advances one dot. For an error-free line, the first active clock of the pulse is dot (P+1)×8 of that line.
- R6: An error-free line carries exactly one pulse, high for (L+1)×8 consecutive clocks.
- R7: A write accepted on any clock edge of a line, including the edge that leaves the line's last dot, takes effect from the first dot of the next line. The line in progress keeps its old pulse.
- R8: The error flag rises one clock after the first dot of a line whose settings in service break either rule, T ≥ P+L+1 or P ≥ D+1, where D is the display-width input. While the flag is high, both sync outputs are low.
- R9: Once high, the error flag stays high until reset, even if legal settings are written afterwards.
- R10: The line-clock strobe and Hsync are equal on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Write strobe for the configuration word |
| cfg_wr_data | input | 16 | Configuration word to write |
| cfg_rd_data | output | 16 | Programmed configuration word, reserved bits zero |
| line_total_chars | input | CHAR_W (8) | Line length T in characters, minus one |
| disp_chars | input | CHAR_W (8) | Visible display width D in characters |
| line_clk_o | output | 1 | Line-clock sync strobe, active high |
| hsync_o | output | 1 | Horizontal sync, active high |
| cfg_err_o | output | 1 | Sticky illegal-settings flag |

## Verification
Two functions can land on the same clock edge: a configuration write, and the line-boundary transfer of the shadow word into service. The bench provokes this by issuing a write exactly on the edge that leaves the last dot of a line. It then checks that the very next line already carries the new pulse at the expected dot, and that no partial pulse appears.

A second collision is between an illegal write and the pulse logic. A bad word is written mid-line. The bench confirms that the error flag stays low through the rest of that line, rises one clock into the next line, and keeps the outputs silent after legal values are written again.

// File: rtl/hsg_pkg.sv
package hsg_pkg;
  localparam int DOTS_PER_CHAR = 8;
  localparam int DOT_W         = $clog2(DOTS_PER_CHAR);
  localparam int REG_W         = 16;
  localparam int WID_W         = 4;
  localparam int POS_W         = 8;
  localparam int WID_LSB       = 12;
  localparam int RSV_LSB       = POS_W;
  localparam int RSV_W         = WID_LSB - POS_W;

  localparam logic [WID_W-1:0] WID_RST = '0;
  localparam logic [POS_W-1:0] POS_RST = 8'h50;

  typedef struct packed {
    logic [WID_W-1:0] width;
    logic [POS_W-1:0] pos;
  } hs_cfg_t;

  localparam hs_cfg_t CFG_RST = '{width: WID_RST, pos: POS_RST};

  function automatic hs_cfg_t cfg_unpack(input logic [REG_W-1:0] word);
    hs_cfg_t c;
    c.width = word[WID_LSB +: WID_W];
    c.pos   = word[0 +: POS_W];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] cfg_pack(input hs_cfg_t c);
    logic [REG_W-1:0] word;
    word = '0;
    word[WID_LSB +: WID_W] = c.width;
    word[0 +: POS_W]       = c.pos;
    return word;
  endfunction
endpackage

// File: rtl/hsg_regs.sv
module hsg_regs
  import hsg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             line_end,
  output logic [REG_W-1:0] rd_data,
  output hs_cfg_t          act_cfg
);
  hs_cfg_t shadow_q;
  hs_cfg_t wr_cfg;
  logic    unused_rsv;

  assign wr_cfg     = cfg_unpack(wr_data);
  assign unused_rsv = ^wr_data[RSV_LSB +: RSV_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_q <= CFG_RST;
    else if (wr_en) shadow_q <= wr_cfg;
  end

  // a write on the last dot is forwarded so it still makes the next line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_cfg <= CFG_RST;
    else if (line_end) act_cfg <= wr_en ? wr_cfg : shadow_q;
  end

  assign rd_data = cfg_pack(shadow_q);
endmodule

// File: rtl/hsg_counters.sv
module hsg_counters
  import hsg_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHAR_W-1:0] line_total,
  output logic [DOT_W-1:0]  dot_cnt,
  output logic [CHAR_W-1:0] char_cnt,
  output logic              line_end
);
  localparam logic [DOT_W-1:0] DOT_LAST = DOT_W'(DOTS_PER_CHAR - 1);

  logic dot_last;

  assign dot_last = (dot_cnt == DOT_LAST);
  assign line_end = dot_last && (char_cnt >= line_total);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dot_cnt <= '0;
    else if (dot_last) dot_cnt <= '0;
    else dot_cnt <= dot_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) char_cnt <= '0;
    else if (line_end) char_cnt <= '0;
    else if (dot_last) char_cnt <= char_cnt + 1'b1;
  end
endmodule

// File: rtl/hsg_sync.sv
module hsg_sync
  import hsg_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int N_OUT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hs_cfg_t           act_cfg,
  input  logic [CHAR_W-1:0] line_total,
  input  logic [CHAR_W-1:0] disp_width,
  input  logic [DOT_W-1:0]  dot_cnt,
  input  logic [CHAR_W-1:0] char_cnt,
  output logic [N_OUT-1:0]  sync_o,
  output logic              err_o
);
  localparam int SUM_W = ((CHAR_W > POS_W) ? CHAR_W : POS_W) + 2;
  localparam logic [DOT_W-1:0] PRE_DOT = DOT_W'(DOTS_PER_CHAR - 2);

  logic [SUM_W-1:0] pos_x, stop_x, char_x, total_x, disp_x;
  logic             at_start, at_stop, err_cond, err_next, sync_d;
  logic             err_q;

  assign pos_x   = SUM_W'(act_cfg.pos);
  assign stop_x  = pos_x + SUM_W'(act_cfg.width) + SUM_W'(1);
  assign char_x  = SUM_W'(char_cnt);
  assign total_x = SUM_W'(line_total);
  assign disp_x  = SUM_W'(disp_width);

  // edges are decoded one dot early so the registered output lands on time
  assign at_start = (dot_cnt == PRE_DOT) && (char_x == pos_x);
  assign at_stop  = (dot_cnt == PRE_DOT) && (char_x == stop_x);

  assign err_cond = (total_x < stop_x) || (pos_x < disp_x + SUM_W'(1));
  assign err_next = err_q || err_cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else err_q <= err_next;
  end

  always_comb begin
    if (err_next)      sync_d = 1'b0;
    else if (at_start) sync_d = 1'b1;
    else if (at_stop)  sync_d = 1'b0;
    else               sync_d = sync_o[0];
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_o[g] <= 1'b0;
      else sync_o[g] <= sync_d;
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/hsync_timing_gen.sv
module hsync_timing_gen
  import hsg_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [15:0]       cfg_wr_data,
  output logic [15:0]       cfg_rd_data,
  input  logic [CHAR_W-1:0] line_total_chars,
  input  logic [CHAR_W-1:0] disp_chars,
  output logic              line_clk_o,
  output logic              hsync_o,
  output logic              cfg_err_o
);
  hs_cfg_t           act_cfg;
  logic [DOT_W-1:0]  dot_cnt;
  logic [CHAR_W-1:0] char_cnt;
  logic              line_end;
  logic [1:0]        sync_pair;

  hsg_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_en),
    .wr_data  (cfg_wr_data),
    .line_end (line_end),
    .rd_data  (cfg_rd_data),
    .act_cfg  (act_cfg)
  );

  hsg_counters #(.CHAR_W(CHAR_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_total (line_total_chars),
    .dot_cnt    (dot_cnt),
    .char_cnt   (char_cnt),
    .line_end   (line_end)
  );

  hsg_sync #(.CHAR_W(CHAR_W), .N_OUT(2)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_cfg    (act_cfg),
    .line_total (line_total_chars),
    .disp_width (disp_chars),
    .dot_cnt    (dot_cnt),
    .char_cnt   (char_cnt),
    .sync_o     (sync_pair),
    .err_o      (cfg_err_o)
  );

  assign line_clk_o = sync_pair[0];
  assign hsync_o    = sync_pair[1];
endmodule

// File: rtl/hsg_checker.sv
module hsg_checker #(
  parameter int DOT_W = 3,
  parameter int WID_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hsync,
  input logic             line_clk,
  input logic             err,
  input logic [15:0]      rd_data,
  input logic [DOT_W-1:0] dot,
  input logic [WID_W-1:0] act_w
);
  localparam logic [DOT_W-1:0] DOT_LAST = '1;

  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= '0;
    else if (hsync) hi_cnt <= hi_cnt + 16'd1;
    else hi_cnt <= '0;
  end

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[11:8] == 4'h0);

  a_r4_dot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (dot == DOT_LAST) |=> (dot == '0));

  a_r4_dot_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dot != DOT_LAST) |=> (dot == DOT_W'($past(dot) + 1'b1)));

  a_r5_rise_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync) |-> (dot == DOT_LAST));

  a_r6_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hsync) && !err) |-> (hi_cnt == 16'((act_w + 1) * 8)));

  a_r8_err_silences: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!hsync && !line_clk));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

bind hsync_timing_gen hsg_checker #(.DOT_W(hsg_pkg::DOT_W), .WID_W(hsg_pkg::WID_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hsync    (hsync_o),
  .line_clk (line_clk_o),
  .err      (cfg_err_o),
  .rd_data  (cfg_rd_data),
  .dot      (dot_cnt),
  .act_w    (act_cfg.width)
);

// File: tb/hsync_timing_gen_bench.sv
module hsync_timing_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [7:0]  ht_in = 8'd99;
  logic [7:0]  dw_in = 8'd10;
  logic        line_clk, hsync, err;

  int errors = 0;
  int checks = 0;

  int  ln_len, idx, cur_p, cur_w, pend_p, pend_w;
  bit  err_m;
  int  mm, mm_idx, mm_act, mm_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsync_timing_gen u_hsync_timing_gen (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_wr_en        (wr_en),
    .cfg_wr_data      (wr_data),
    .cfg_rd_data      (rd_data),
    .line_total_chars (ht_in),
    .disp_chars       (dw_in),
    .line_clk_o       (line_clk),
    .hsync_o          (hsync),
    .cfg_err_o        (err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp_v);
    end
  endtask

  function automatic bit illegal(input int p, input int w);
    return (int'(ht_in) < p + w + 1) || (p < int'(dw_in) + 1);
  endfunction

  function automatic bit in_win(input int i, input int p, input int w);
    return (i >= (p + 1) * 8 - 1) && (i <= (p + w + 2) * 8 - 2);
  endfunction

  task automatic apply_reset(input int ht, input int dw);
    rst_n = 1'b0;
    wr_en = 1'b0;
    ht_in = 8'(ht);
    dw_in = 8'(dw);
    repeat (3) @(posedge clk);
    ln_len = (ht + 1) * 8;
    idx = 0; cur_p = 'h50; cur_w = 0; pend_p = 'h50; pend_w = 0;
    err_m = 1'b0; mm = 0; mm_idx = 0; mm_act = 0; mm_exp = 0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic step();
    bit e;
    @(posedge clk);
    if (illegal(cur_p, cur_w)) err_m = 1'b1;
    if (wr_en) begin
      pend_p = int'(wr_data[7:0]);
      pend_w = int'(wr_data[15:12]);
    end
    if (idx == ln_len - 1) begin
      idx = 0; cur_p = pend_p; cur_w = pend_w;
    end else begin
      idx++;
    end
    #1;
    e = !err_m && in_win(idx, cur_p, cur_w);
    if (hsync !== e || line_clk !== e || err !== err_m) begin
      if (mm == 0) begin
        mm_idx = idx;
        mm_act = {29'd0, hsync, line_clk, err};
        mm_exp = {29'd0, e, e, err_m};
      end
      mm++;
    end
  endtask

  task automatic run_to(input int target);
    do step(); while (idx != target);
  endtask

  task automatic write_step(input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic model_check(input string req);
    check(mm == 0, req, $sformatf("model match {hs,lc,err} (first miss at dot idx %0d)", mm_idx),
          mm_act, mm_exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    ht_in = 8'd99;
    dw_in = 8'd10;
    repeat (2) @(posedge clk);
    #1;
    check(rd_data == 16'h0050, "R1", "read word in reset", rd_data, 16'h0050);
    check(!hsync && !line_clk && !err, "R1", "outputs in reset",
          {hsync, line_clk, err}, 0);
    apply_reset(99, 10);
    check(rd_data == 16'h0050, "R1", "read word after release", rd_data, 16'h0050);
  endtask

  task automatic t_default_timing();
    // boundaries: T = P+L+1 = 81 and P = D+1 = 80
    apply_reset(81, 79);
    run_to(646);
    check(hsync == 1'b0, "R5", "dot 647 idle", hsync, 0);
    step();
    check(hsync == 1'b1, "R5", "dot 648 active", hsync, 1);
    run_to(654);
    check(hsync == 1'b1, "R6", "dot 655 active", hsync, 1);
    step();
    check(hsync == 1'b0, "R6", "dot 656 idle", hsync, 0);
    run_to(0);
    run_to(647);
    check(hsync == 1'b1, "R4", "next line rises after 656 clocks", hsync, 1);
    run_to(0);
    model_check("R10");
    check(err == 1'b0, "R8", "boundary-legal settings", err, 0);
  endtask

  task automatic t_regs();
    apply_reset(99, 10);
    write_step(16'hFFFF);
    check(rd_data == 16'hF0FF, "R3", "reserved bits read zero", rd_data, 16'hF0FF);
    write_step(16'h3A5C);
    check(rd_data == 16'h305C, "R2", "fields read back", rd_data, 16'h305C);
  endtask

  task automatic t_deferred();
    apply_reset(99, 10);
    run_to(300);
    write_step(16'h2014);
    check(rd_data == 16'h2014, "R2", "shadow read before use", rd_data, 16'h2014);
    run_to(647);
    check(hsync == 1'b1, "R7", "old pulse kept in current line", hsync, 1);
    run_to(0);
    run_to(166);
    check(hsync == 1'b0, "R7", "new line idle before new start", hsync, 0);
    step();
    check(hsync == 1'b1, "R5", "new pulse starts at dot 168", hsync, 1);
    run_to(190);
    check(hsync == 1'b1, "R6", "24-clock pulse still high", hsync, 1);
    step();
    check(hsync == 1'b0, "R6", "24-clock pulse ended", hsync, 0);
    run_to(0);
    model_check("R4");
  endtask

  task automatic t_coincide();
    apply_reset(99, 10);
    run_to(ln_len - 1);
    write_step(16'h100C);
    run_to(102);
    check(hsync == 1'b0, "R7", "last-dot write: idle before start", hsync, 0);
    step();
    check(hsync == 1'b1, "R7", "last-dot write applied to next line", hsync, 1);
    run_to(0);
    run_to(0);
    model_check("R7");
  endtask

  task automatic t_err_disp();
    apply_reset(99, 80);
    step();
    check(err == 1'b1, "R8", "position below display width + 1", err, 1);
    run_to(0);
    model_check("R8");
  endtask

  task automatic t_err_total();
    apply_reset(80, 79);
    step();
    check(err == 1'b1, "R8", "line total below P+L+1", err, 1);
    run_to(0);
    model_check("R8");
  endtask

  task automatic t_sticky();
    apply_reset(99, 10);
    run_to(50);
    write_step(16'h0005);
    run_to(ln_len - 1);
    check(err == 1'b0, "R7", "illegal word not yet in service", err, 0);
    step();
    check(err == 1'b0, "R8", "flag low on first dot", err, 0);
    step();
    check(err == 1'b1, "R8", "flag high one clock into line", err, 1);
    write_step(16'h0050);
    run_to(0);
    run_to(0);
    check(err == 1'b1, "R9", "flag stays after legal rewrite", err, 1);
    model_check("R9");
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_default_timing();
    t_regs();
    t_deferred();
    t_coincide();
    t_err_disp();
    t_err_total();
    t_sticky();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule